// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block sequences the four drive strobes of a single unipolar stepper motor that several machine functions share. A two-bit function code says which function currently owns the motor. One code selects half-step excitation, which alternates between one and two energised windings. The other three codes select full-step excitation, where two windings are on at every step. A prescaler divides the system clock down to a fixed step rate, 100 steps per second by default, and every function uses the same rate.

The controller raises a run enable to move the motor and uses a direction input to choose forward or reverse travel. When run falls, the strobes drop at once. The position inside the sequence is kept, so motion picks up again from the same place. Direction and function changes are sampled only on a step tick. When the motor moves from half-step to full-step on a single-winding position, it goes to the neighbouring two-winding pattern in the direction of travel.

Top module: `stepper_phase_seq`

## Requirements
- R1: While rst_n is low, and on the first edge after reset, drive_o is 0. The held position after reset is the pattern A+B. drive_o bit 0 is winding A, bit 1 is B, bit 2 is C and bit 3 is D.
- R2: While run_i is high, a step happens exactly once every DIV = CLK_HZ/STEP_HZ clocks. The first step comes DIV clocks after run_i is first sampled high. Between steps, drive_o stays stable.
- R3: Function codes 0, 1 and 2 use full-step excitation. Forward travel repeats A+B, B+C, C+D, D+A, and every step leaves exactly two windings on.
- R4: Function code 3 uses half-step excitation. Forward travel repeats A, A+B, B, B+C, C, C+D, D, D+A, so each step changes the number of windings on between one and two.
- R5: dir_rev_i = 1 runs the active sequence in reverse order. Direction is sampled only on a step tick, so a change between ticks takes effect at the next step.
- R6: After any edge where run_i is sampled low, drive_o is 0 and the prescaler restarts. The position is kept, and when run_i is raised again, drive_o shows the same pattern it had before the stop.
- R7: A change of function code takes effect at the next step tick. If full-step is entered while a single winding is on, that tick moves to the adjacent two-winding pattern that contains this winding, in the direction of travel.
- R8: drive_o never has more than two windings on, and two windings that are on together are always neighbours in the cycle A, B, C, D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Motion enable; when low, all strobes are forced off |
| dir_rev_i | input | 1 | 0 = forward sequence order, 1 = reverse |
| func_i | input | 2 | Function code; 0 to 2 give full-step, 3 gives half-step |
| drive_o | output | 4 | Active-high winding strobes A (bit 0) to D (bit 3) |

## Verification
A wrong position register shows up as a drive pattern that differs from the expected one on the next step tick, which is at most DIV clocks later. The bench compares drive_o against an arithmetic model on every clock. A prescaler that counts wrongly moves the step edge by at least one clock, and this shows up within one step period of enabling. A wrong step delta or mode mapping appears at the first tick after the change as a wrong pattern, as a pair of windings that are not neighbours, or as a winding count that does not alternate.

// File: rtl/stepper_pkg.sv
// Shared definitions for the stepper phase sequencer.
// Assumes a four-winding motor whose positions are counted in half-step units.
package stepper_pkg;

    localparam int NUM_WINDINGS = 4;
    localparam int POS_STEPS    = 2 * NUM_WINDINGS;
    localparam int POS_W        = $clog2(POS_STEPS);

    // Function codes: the only half-step owner is FN_FINE.
    typedef enum logic [1:0] {
        FN_GENERAL = 2'd0,
        FN_SWING   = 2'd1,
        FN_EJECT   = 2'd2,
        FN_FINE    = 2'd3
    } func_e;

    // Position of the A+B pattern, used as the reset position.
    localparam logic [POS_W-1:0] POS_HOME = POS_W'(1);

    // Returns true when the function code asks for half-step excitation.
    function automatic logic is_half_step(input logic [1:0] code);
        return code == FN_FINE;
    endfunction

endpackage

// File: rtl/step_rate_gen.sv
// Step-rate prescaler: emits a one-clock tick after every DIV clocks of run.
// Assumes DIV >= 2. The count restarts from zero whenever run is low.
module step_rate_gen #(
    parameter int DIV = 10_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    // Count enabled clocks and wrap on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/step_phase_ctr.sv
// Position counter in half-step units, modulo eight.
// When a tick comes, half-step moves one position. Full-step moves two positions
// from a two-winding pattern, or one position from a single-winding pattern so
// that it lands on the neighbouring pair in the direction of travel.
module step_phase_ctr
    import stepper_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             half_mode,
    input  logic             rev,
    output logic [POS_W-1:0] pos_q,
    output logic [POS_W-1:0] pos_next
);
    logic [POS_W-1:0] delta;

    // Choose the step size from the mode and the parity of the current position.
    always_comb begin
        if (!half_mode && pos_q[0]) begin
            delta = POS_W'(2);
        end else begin
            delta = POS_W'(1);
        end
    end

    // Work out the next position; the modulo wrap comes from the register width.
    always_comb begin
        if (!tick) begin
            pos_next = pos_q;
        end else if (rev) begin
            pos_next = pos_q - delta;
        end else begin
            pos_next = pos_q + delta;
        end
    end

    // Hold the position register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= POS_HOME;
        end else begin
            pos_q <= pos_next;
        end
    end

endmodule

// File: rtl/step_pattern_map.sv
// Maps a half-step position to winding strobes. Winding w is on at position 2w
// and at the two positions next to it. This yields A, A+B, B, B+C, and so on.
module step_pattern_map
    import stepper_pkg::*;
(
    input  logic [POS_W-1:0]        pos,
    output logic [NUM_WINDINGS-1:0] pattern
);
    for (genvar w = 0; w < NUM_WINDINGS; w++) begin : g_wind
        localparam logic [POS_W-1:0] CENTER = POS_W'(2 * w);
        localparam logic [POS_W-1:0] AFTER  = CENTER + POS_W'(1);
        localparam logic [POS_W-1:0] BEFORE = CENTER - POS_W'(1);
        // Winding w is energised around its centre position.
        assign pattern[w] = (pos == CENTER) || (pos == AFTER) || (pos == BEFORE);
    end

endmodule

// File: rtl/stepper_phase_seq.sv
// Top level of the stepper phase sequencer. It combines the prescaler, the
// position counter and the pattern map, and registers the strobes.
// Assumes CLK_HZ is a multiple of STEP_HZ and that inputs are synchronous to clk.
module stepper_phase_seq
    import stepper_pkg::*;
#(
    parameter int CLK_HZ  = 1_000_000,
    parameter int STEP_HZ = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       dir_rev_i,
    input  logic [1:0] func_i,
    output logic [3:0] drive_o
);
    localparam int DIV = CLK_HZ / STEP_HZ;

    logic                    tick;
    logic                    half_mode;
    logic [POS_W-1:0]        pos_q;
    logic [POS_W-1:0]        pos_next;
    logic [NUM_WINDINGS-1:0] pattern_next;

    assign half_mode = is_half_step(func_i);

    step_rate_gen #(.DIV(DIV)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_i),
        .tick  (tick)
    );

    step_phase_ctr u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .half_mode (half_mode),
        .rev       (dir_rev_i),
        .pos_q     (pos_q),
        .pos_next  (pos_next)
    );

    step_pattern_map u_map (
        .pos     (pos_next),
        .pattern (pattern_next)
    );

    // Register the strobes; they are forced off while run is low.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            drive_o <= '0;
        end else begin
            drive_o <= pattern_next;
        end
    end

endmodule

// File: rtl/stepper_phase_seq_chk.sv
// Assertion checker for the stepper phase sequencer, bound to the top module.
// It keeps its own tick-spacing counter so that it does not rely on the prescaler.
module stepper_phase_seq_chk #(
    parameter int DIV = 10_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       run_i,
    input logic [1:0] func_i,
    input logic       tick,
    input logic [3:0] drive_o
);
    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] gap_q;

    // Count clocks since run was raised or since the last step.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || gap_q == LAST) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + W'(1);
        end
    end

    // R2: a step tick comes only once a full prescaler period has passed.
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q == LAST));

    // R2: the strobes do not change between ticks while running.
    a_r2_steady_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick && drive_o != 4'b0) |=> (drive_o == $past(drive_o)));

    // R3: a full-step tick leaves two windings on.
    a_r3_full_two_windings: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && func_i != 2'd3) |=> ($countones(drive_o) == 2));

    // R4: a half-step tick changes the number of windings on.
    a_r4_half_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && func_i == 2'd3) |=> ($countones(drive_o) != $countones($past(drive_o))));

    // R6: a low run clears the strobes on the next edge.
    a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (drive_o == 4'b0));

    // R8: at most two windings are on, and a pair is always made of neighbours.
    a_r8_adjacent_only: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(drive_o) <= 2) && (drive_o != 4'b0101) && (drive_o != 4'b1010));

endmodule

bind stepper_phase_seq stepper_phase_seq_chk #(.DIV(DIV)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run_i),
    .func_i  (func_i),
    .tick    (tick),
    .drive_o (drive_o)
);

// File: tb/stepper_phase_seq_test.sv
// Bench: compares drive_o on every clock against an arithmetic model built
// from the requirements. It uses a small divisor (800 Hz / 100 Hz = 8).
module stepper_phase_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int TB_CLK_HZ  = 800;
    localparam int TB_STEP_HZ = 100;
    localparam int DIV        = TB_CLK_HZ / TB_STEP_HZ;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       run_i;
    logic       dir_rev_i;
    logic [1:0] func_i;
    logic [3:0] drive_o;

    int checks   = 0;
    int failures = 0;
    int m_pos    = 1;
    int m_cnt    = 0;
    logic [3:0] m_drive = 4'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stepper_phase_seq #(.CLK_HZ(TB_CLK_HZ), .STEP_HZ(TB_STEP_HZ)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_i),
        .dir_rev_i (dir_rev_i),
        .func_i    (func_i),
        .drive_o   (drive_o)
    );

    // Pattern at half-step position k: even k is a single winding, odd k is a pair.
    function automatic logic [3:0] pat(input int k);
        int a = k / 2;
        logic [3:0] r = 4'b0001 << a;
        if (k % 2 == 1) r = r | (4'b0001 << ((a + 1) % 4));
        return r;
    endfunction

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: drive_o=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model by one clock edge using the inputs now applied.
    task automatic model_edge();
        int d;
        if (!run_i) begin
            m_cnt = 0;
            m_drive = 4'b0;
        end else begin
            if (m_cnt == DIV - 1) begin
                m_cnt = 0;
                d = (func_i == 2'd3 || m_pos % 2 == 0) ? 1 : 2;
                m_pos = dir_rev_i ? (m_pos - d + 8) % 8 : (m_pos + d) % 8;
            end else begin
                m_cnt++;
            end
            m_drive = pat(m_pos);
        end
    endtask

    task automatic cycles(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            check(drive_o, m_drive, tag);
            // R8: the pattern shape is checked on its own, apart from the model.
            checks++;
            if ($countones(drive_o) > 2 || drive_o == 4'b0101 || drive_o == 4'b1010) begin
                failures++;
                $display("FAIL R8: drive_o=%b expected an adjacent pattern", drive_o);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; run_i = 1'b1; dir_rev_i = 1'b0; func_i = 2'd0;
        repeat (3) @(negedge clk);
        check(drive_o, 4'b0000, "R1 reset");
        run_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_pos = 1; m_cnt = 0;
        // R1: the first enable shows the home pattern A+B.
        run_i = 1'b1;
        cycles(1, "R1 home");
        check(drive_o, 4'b0011, "R1 home pattern");
        // R2 and R3: full-step forward with the general function.
        cycles(8 * DIV + 2, "R3 full fwd");
        // R5: reverse travel with the swing function.
        func_i = 2'd1; dir_rev_i = 1'b1;
        cycles(4 * DIV, "R5 full rev");
        // R5: direction flips between ticks and is taken at the boundary.
        func_i = 2'd2;
        cycles(DIV / 2, "R5 mid");
        dir_rev_i = 1'b0;
        cycles(2 * DIV, "R5 boundary");
        // R6: stop in mid-period, hold, then resume from the same place.
        run_i = 1'b0;
        cycles(5, "R6 stopped");
        run_i = 1'b1;
        cycles(1, "R6 resume");
        check(drive_o, pat(m_pos), "R6 held position");
        cycles(3 * DIV, "R6 restart period");
        // R4: half-step in both directions.
        func_i = 2'd3;
        cycles(10 * DIV, "R4 half fwd");
        dir_rev_i = 1'b1;
        cycles(6 * DIV, "R4 half rev");
        // R7: enter full-step from a single-winding position, once per direction.
        for (int dr = 0; dr < 2; dr++) begin
            func_i = 2'd3; dir_rev_i = dr[0];
            while (m_pos % 2 == 1) cycles(1, "R7 align");
            func_i = 2'd0;
            cycles(3 * DIV, "R7 mode switch");
        end
        // R2, R3 and R4: sweep over all function codes and directions with stops in between.
        for (int f = 0; f < 4; f++) begin
            for (int dr = 0; dr < 2; dr++) begin
                func_i = f[1:0]; dir_rev_i = dr[0];
                cycles(3 * DIV + 1, "R2 sweep");
                run_i = 1'b0;
                cycles(2, "R6 sweep stop");
                run_i = 1'b1;
            end
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule